// File: doc/BRIEF.md
# USB Device Address Holding Register

This block stores the USB device address and the device-enable flag for a peripheral controller. A local microcontroller reaches it through a byte-wide command port. One opcode loads a byte into a programmer-visible register and another returns that byte. The byte's top bit is the enable flag. Its lower seven bits are the address.

The bus-side token matcher does not read the visible register. It reads a separate active copy, made of an active address and an enable. A newly written byte is only held pending. It moves into the active copy when the host acknowledges the zero-length status packet that follows. A USB bus reset clears the active address, turns the device on and cancels any pending activation. It never touches the visible register, so firmware can still read back what it wrote.

Top module: `usb_devaddr_reg`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), the visible register, `rd_data`, `act_addr` and `dev_enable` are all zero.
- R2: A command with `cmd_valid` high and opcode B6h stores `cmd_wdata` in the visible register. A command with opcode B7h puts the visible register on `rd_data` at the next edge, and `rd_data` holds that value until the next read. A read issued right after a write returns the written byte.
- R3: A write does not change `act_addr` or `dev_enable`. They change only on a bus reset or on an acknowledge that applies a pending value.
- R4: A `status_ack` pulse while a write is pending loads bit 7 of the most recently written byte into `dev_enable` and bits 6:0 into `act_addr` at that clock edge. The pending state is then cleared.
- R5: A `status_ack` pulse with no write pending leaves `act_addr` and `dev_enable` unchanged.
- R6: A `bus_reset` pulse sets `act_addr` to 0 and `dev_enable` to 1 at that edge, and leaves the visible register unchanged.
- R7: A `bus_reset` cancels a pending write, so a later `status_ack` has no effect until a new write is made.
- R8: When `bus_reset` and `status_ack` are high in the same cycle, the bus reset wins: the result is address 0, enable 1, and nothing left pending.
- R9: Commands with any opcode other than B6h and B7h, and any inputs while `cmd_valid` is low, change neither the visible register nor `rd_data`.
- R10: If a write and a `status_ack` come in the same cycle, the acknowledge activates the byte that was pending before that edge, and the new byte stays pending for the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 8 | Command opcode |
| cmd_wdata | input | 8 | Byte for a write command |
| bus_reset | input | 1 | Single-cycle USB bus-reset pulse |
| status_ack | input | 1 | Single-cycle pulse: host acknowledged the empty status packet |
| act_addr | output | 7 | Active device address used for token matching |
| dev_enable | output | 1 | Active device enable |
| rd_data | output | 8 | Read-back byte from the last read command |

## Verification
Every result is due exactly one edge after its stimulus. A write appears on `rd_data` one edge after a read that follows it. An acknowledge or bus reset moves `act_addr` and `dev_enable` at the edge that samples the pulse. The bench drives inputs on the falling edge and compares all three outputs with a behavioural model on every falling edge, half a period after the rising edge that updates them. Directed checks at the same points confirm the literal values each scenario expects.

// File: rtl/devaddr_pkg.sv
// Package: shared constants for the device-address block.
// Assumes: opcode values are fixed by the command set and used by the decoder.
package devaddr_pkg;
    localparam int OP_W          = 8;
    localparam logic [7:0] OP_WR = 8'hB6;
    localparam logic [7:0] OP_RD = 8'hB7;
endpackage

// File: rtl/devaddr_cmd_decode.sv
// Module: turns a command strobe plus opcode into write/read strobes.
// Assumes: one command per cycle; unknown opcodes produce no strobe.
module devaddr_cmd_decode #(
    parameter int             OP_W  = 8,
    parameter logic [OP_W-1:0] WR_OP = 8'hB6,
    parameter logic [OP_W-1:0] RD_OP = 8'hB7
) (
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    output logic            wr_stb,
    output logic            rd_stb
);
    // Purpose: opcode match gated by the command strobe.
    always_comb begin
        wr_stb = cmd_valid && (cmd_op == WR_OP);
        rd_stb = cmd_valid && (cmd_op == RD_OP);
    end
endmodule

// File: rtl/devaddr_shadow.sv
// Module: visible register, read-back latch and pending-activation flag.
// Assumes: bus_reset and status_ack are single-cycle pulses in clk domain.
module devaddr_shadow #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bus_reset,
    input  logic              status_ack,
    output logic [DATA_W-1:0] vis_q,
    output logic [DATA_W-1:0] rd_q,
    output logic              apply
);
    logic pend_q;

    // Purpose: an acknowledge applies only a pending byte, and loses to a bus reset.
    always_comb apply = status_ack && pend_q && !bus_reset;

    // Purpose: hold the firmware-visible byte; a bus reset does not touch it.
    always_ff @(posedge clk) begin
        if (!rst_n)      vis_q <= '0;
        else if (wr_stb) vis_q <= wdata;
    end

    // Purpose: latch the visible byte on a read command.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_stb) rd_q <= vis_q;
    end

    // Purpose: track whether a written byte still awaits activation.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (bus_reset) pend_q <= 1'b0;
        else if (wr_stb)    pend_q <= 1'b1;
        else if (apply)     pend_q <= 1'b0;
    end

    assert_vis_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !wr_stb) |=> $stable(vis_q));
    assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !pend_q);
    assert_rd_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_q));
endmodule

// File: rtl/devaddr_active.sv
// Module: active address and enable seen by the bus-side token matcher.
// Assumes: apply is already gated against bus_reset by the shadow logic.
module devaddr_active #(
    parameter int ADDR_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_reset,
    input  logic            apply,
    input  logic [ADDR_W:0] new_byte,
    output logic [ADDR_W-1:0] act_addr,
    output logic            act_en
);
    // Purpose: bus reset forces address zero and enable; acknowledge loads pending byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_addr <= '0;
            act_en   <= 1'b0;
        end else if (bus_reset) begin
            act_addr <= '0;
            act_en   <= 1'b1;
        end else if (apply) begin
            act_addr <= new_byte[ADDR_W-1:0];
            act_en   <= new_byte[ADDR_W];
        end
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_reset && !apply) |=> ($stable(act_addr) && $stable(act_en)));
    assert_busrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (act_addr == '0 && act_en));
endmodule

// File: rtl/usb_devaddr_reg.sv
// Module: top of the USB device-address register block.
// Assumes: command, bus-reset and acknowledge inputs are synchronous to clk.
module usb_devaddr_reg #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W:0]   cmd_wdata,
    input  logic              bus_reset,
    input  logic              status_ack,
    output logic [ADDR_W-1:0] act_addr,
    output logic              dev_enable,
    output logic [ADDR_W:0]   rd_data
);
    import devaddr_pkg::*;
    localparam int DATA_W = ADDR_W + 1;

    logic              wr_stb, rd_stb, apply;
    logic [DATA_W-1:0] vis_q;

    devaddr_cmd_decode #(.OP_W(OP_W), .WR_OP(OP_WR), .RD_OP(OP_RD)) u_dec (
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    devaddr_shadow #(.DATA_W(DATA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(cmd_wdata), .bus_reset(bus_reset), .status_ack(status_ack),
        .vis_q(vis_q), .rd_q(rd_data), .apply(apply)
    );

    devaddr_active #(.ADDR_W(ADDR_W)) u_active (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .apply(apply),
        .new_byte(vis_q), .act_addr(act_addr), .act_en(dev_enable)
    );

    assert_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (act_addr == $past(vis_q[ADDR_W-1:0]) && dev_enable == $past(vis_q[ADDR_W])));
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data == $past(vis_q)));
    assert_ack_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ack && !apply && !bus_reset) |=> ($stable(act_addr) && $stable(dev_enable)));
endmodule

// File: tb/usb_devaddr_reg_bench.sv
module usb_devaddr_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_op = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic       bus_reset = 1'b0;
    logic       status_ack = 1'b0;
    logic [6:0] act_addr;
    logic       dev_enable;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // behavioural reference state
    int m_vis = 0, m_rd = 0, m_addr = 0, m_en = 0;
    bit m_pend = 0;

    always #5 clk = ~clk;

    usb_devaddr_reg u_usb_devaddr_reg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wdata(cmd_wdata), .bus_reset(bus_reset), .status_ack(status_ack),
        .act_addr(act_addr), .dev_enable(dev_enable), .rd_data(rd_data)
    );

    // reference model: next state from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_vis <= 0; m_rd <= 0; m_addr <= 0; m_en <= 0; m_pend <= 0;
        end else begin
            bit wr, rd, pend_n;
            wr = cmd_valid && cmd_op == 8'hB6;
            rd = cmd_valid && cmd_op == 8'hB7;
            pend_n = m_pend;
            if (bus_reset) begin
                m_addr <= 0; m_en <= 1; pend_n = 0;
            end else if (status_ack && m_pend) begin
                m_addr <= m_vis % 128; m_en <= m_vis / 128; pend_n = 0;
            end
            if (wr && !bus_reset) pend_n = 1;
            m_pend <= pend_n;
            if (wr) m_vis <= cmd_wdata;
            if (rd) m_rd <= m_vis;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(phase, act_addr, m_addr, "model act_addr");
            check(phase, dev_enable, m_en, "model dev_enable");
            check(phase, rd_data, m_rd, "model rd_data");
        end
    end

    task automatic step(bit v, logic [7:0] op, logic [7:0] d, bit br, bit ak);
        cmd_valid = v; cmd_op = op; cmd_wdata = d; bus_reset = br; status_ack = ak;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 8'h00; cmd_wdata = 8'h00; bus_reset = 0; status_ack = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", act_addr, 0, "act_addr"); check("R1", dev_enable, 0, "dev_enable");
        check("R1", rd_data, 0, "rd_data");
        // R2 / R3 write then read back
        phase = "R2";
        step(1, 8'hB6, 8'h85, 0, 0);
        check("R3", act_addr, 0, "act_addr after write"); check("R3", dev_enable, 0, "enable after write");
        step(1, 8'hB7, 8'h00, 0, 0);
        check("R2", rd_data, 8'h85, "readback");
        // R4 activation
        phase = "R4";
        step(0, 8'h00, 8'h00, 0, 1);
        check("R4", act_addr, 5, "act_addr"); check("R4", dev_enable, 1, "dev_enable");
        // R5 ack without pending
        phase = "R5";
        step(0, 8'h00, 8'h00, 0, 1);
        check("R5", act_addr, 5, "act_addr");
        // R4 most recent wins
        phase = "R4";
        step(1, 8'hB6, 8'h23, 0, 0);
        step(1, 8'hB6, 8'hAA, 0, 0);
        step(0, 8'h00, 8'h00, 0, 1);
        check("R4", act_addr, 8'h2A, "act_addr latest"); check("R4", dev_enable, 1, "enable latest");
        // R6 bus reset
        phase = "R6";
        step(0, 8'h00, 8'h00, 1, 0);
        check("R6", act_addr, 0, "act_addr"); check("R6", dev_enable, 1, "dev_enable");
        step(1, 8'hB7, 8'h00, 0, 0);
        check("R6", rd_data, 8'hAA, "visible kept");
        // R7 cancel pending
        phase = "R7";
        step(1, 8'hB6, 8'h11, 0, 0);
        step(0, 8'h00, 8'h00, 1, 0);
        step(0, 8'h00, 8'h00, 0, 1);
        check("R7", act_addr, 0, "act_addr after cancelled ack");
        // R8 simultaneous
        phase = "R8";
        step(1, 8'hB6, 8'h40, 0, 0);
        step(0, 8'h00, 8'h00, 1, 1);
        check("R8", act_addr, 0, "act_addr"); check("R8", dev_enable, 1, "dev_enable");
        step(0, 8'h00, 8'h00, 0, 1);
        check("R8", act_addr, 0, "nothing left pending");
        // R9 ignored commands
        phase = "R9";
        step(1, 8'hB5, 8'hFF, 0, 0);
        step(0, 8'hB6, 8'h77, 0, 0);
        step(0, 8'hB7, 8'h00, 0, 0);
        check("R9", rd_data, 8'hAA, "rd_data untouched");
        step(1, 8'hB7, 8'h00, 0, 0);
        check("R9", rd_data, 8'h40, "visible untouched");
        // R10 write together with ack
        phase = "R10";
        step(1, 8'hB6, 8'h12, 0, 0);
        step(1, 8'hB6, 8'h34, 0, 1);
        check("R10", act_addr, 8'h12, "old pending applied"); check("R10", dev_enable, 0, "enable");
        step(0, 8'h00, 8'h00, 0, 1);
        check("R10", act_addr, 8'h34, "new byte applied");
        @(negedge clk);
        summary();
    end
endmodule